// File: doc/BRIEF.md
# Unified Data-Space Access Router

This block routes byte loads and stores for a small 8-bit core that sees its working registers, its I/O ports and its data memory as one flat address space. Each cycle the core may present one access: an address, a byte of write data and a read or a write strobe. The block decodes the address into one of three regions. Low addresses reach a local 32-entry register file. The next band reaches 64 I/O ports. Everything above goes out on a byte-wide memory bus.

Eight I/O ports at the top of the port range belong to the core and are held inside the block. Four extended-addressing page registers and one extended-jump page register are kept as 24-bit values whose byte sits in bits 23:16. The block also holds a 16-bit stack pointer, written and read as two halves, and the packed status byte. Writes to the four data page registers and to the upper stack-pointer half are gated by input straps. All other I/O ports, and all memory addresses, become single-cycle strobes on the memory bus. A bus read holds the block busy until the memory answers with a valid pulse.

Top module: `dspace_router`

## Requirements
- R1: An address below 32 selects register-file entry equal to the address. A write stores the byte. A read raises `rd_valid` for one cycle after the accepting edge, with the stored byte on `rd_data`. Neither access causes memory-bus activity.
- R2: An address from 32 to 95 selects I/O port (address − 32). Ports 0x38 to 0x3F are local and never produce a bus strobe. A local read answers one cycle after the accepting edge, like R1.
- R3: Ports 0x38, 0x39, 0x3A and 0x3B are the data page registers D, X, Y and Z. A write loads the byte into bits 23:16 of the matching 24-bit output, with bits 15:0 zero, only while that register's strap is 1. With the strap 0 the write leaves the register unchanged. A read returns bits 23:16.
- R4: Port 0x3C is the jump page register. A write always loads bits 23:16, and a read returns them.
- R5: Port 0x3D writes stack-pointer bits 7:0 and leaves bits 15:8 unchanged. A read returns bits 7:0.
- R6: Port 0x3E writes stack-pointer bits 15:8 only while the wide-stack strap is 1, and is ignored otherwise. A read returns bits 15:8.
- R7: Port 0x3F reads and writes the whole status byte.
- R8: Any other I/O port p gives a one-cycle `mem_wr` or `mem_rd` pulse, one cycle after the accepting edge, at address IO_BASE + p. A write carries its byte on `mem_wdata`.
- R9: An address of 96 or above gives the same kind of bus pulse at address DATA_BASE + address.
- R10: After a bus read, `busy` is high from the cycle after acceptance until the edge that samples `mem_rvalid`. The cycle after that edge, `rd_valid` pulses once with `mem_rdata`. A `mem_rvalid` while no read is outstanding is ignored.
- R11: After reset all page registers, the stack pointer and the status byte read as zero, and `rd_valid`, `mem_rd`, `mem_wr` and `busy` are low.
- R12: `mem_rd` and `mem_wr` are never high together. `rd_valid` never pulses without a prior read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 16 | Data-space address of the access |
| acc_wdata | input | 8 | Write byte |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| strap_page_d | input | 1 | Enables writes to page register D |
| strap_page_x | input | 1 | Enables writes to page register X |
| strap_page_y | input | 1 | Enables writes to page register Y |
| strap_page_z | input | 1 | Enables writes to page register Z |
| strap_wide_sp | input | 1 | Enables writes to the upper stack-pointer half |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Bus read outstanding |
| mem_rd | output | 1 | Bus read strobe |
| mem_wr | output | 1 | Bus write strobe |
| mem_addr | output | 24 | Bus byte address |
| mem_wdata | output | 8 | Bus write byte |
| mem_rvalid | input | 1 | Bus read data valid |
| mem_rdata | input | 8 | Bus read data |
| page_d | output | 24 | Data page register D |
| page_x | output | 24 | Data page register X |
| page_y | output | 24 | Data page register Y |
| page_z | output | 24 | Data page register Z |
| page_jmp | output | 24 | Jump page register |
| stack_ptr | output | 16 | Stack pointer |
| status | output | 8 | Status byte |

## Verification
The assertions assume that the core never raises read and write strobes together. They also assume that no access is presented while `busy` is high, and that the memory answers only an outstanding read. The stimulus follows these rules: it issues one access per task call and waits through the bus latency before the next access. It changes straps only in cycles with no access.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [1:0] {
    RGN_GPR  = 2'd0,
    RGN_SPEC = 2'd1,
    RGN_BUS  = 2'd2
  } region_e;

  typedef struct packed {
    logic wide_sp;
    logic page_z;
    logic page_y;
    logic page_x;
    logic page_d;
  } strap_t;

  // core-owned port numbers; the page registers must stay consecutive
  localparam int PORT_PAGE_BASE = 'h38;
  localparam int PORT_JMP       = 'h3C;
  localparam int PORT_SP_LO     = 'h3D;
  localparam int PORT_SP_HI     = 'h3E;
  localparam int PORT_STATUS    = 'h3F;
  localparam int NUM_PAGE       = 4;

endpackage

// File: rtl/dsr_decode.sv
module dsr_decode
  import dsr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int GPR_COUNT = 32,
  parameter int IO_COUNT  = 64,
  parameter int MEM_AW    = 24,
  parameter int unsigned DATA_BASE = 'h200000,
  parameter int unsigned IO_BASE   = DATA_BASE + GPR_COUNT,
  localparam int PORT_W   = $clog2(IO_COUNT)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [PORT_W-1:0] port,
  output logic [MEM_AW-1:0] bus_addr
);

  localparam int IO_END = GPR_COUNT + IO_COUNT;

  logic [ADDR_W-1:0] io_off;
  logic              unused_io_hi;

  assign io_off       = addr - ADDR_W'(GPR_COUNT);
  assign port         = io_off[PORT_W-1:0];
  assign unused_io_hi = ^io_off[ADDR_W-1:PORT_W];

  always_comb begin
    region   = RGN_BUS;
    bus_addr = MEM_AW'(DATA_BASE) + MEM_AW'(addr);
    if (addr < ADDR_W'(GPR_COUNT)) begin
      region = RGN_GPR;
    end else if (addr < ADDR_W'(IO_END)) begin
      bus_addr = MEM_AW'(IO_BASE) + MEM_AW'(port);
      if (port >= PORT_W'(PORT_PAGE_BASE)) region = RGN_SPEC;
    end
  end

endmodule

// File: rtl/dsr_regfile.sv
module dsr_regfile #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[idx];
  end

endmodule

// File: rtl/dsr_special.sv
module dsr_special
  import dsr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 24,
  parameter int PORT_W = 6,
  localparam int SP_W  = 2 * DATA_W,
  localparam int LOW_W = PAGE_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] port,
  input  logic [DATA_W-1:0] wdata,
  input  strap_t            strap,
  output logic [PAGE_W-1:0] page_o [NUM_PAGE],
  output logic [PAGE_W-1:0] jmp_o,
  output logic [SP_W-1:0]   sp_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] rdata
);

  logic [NUM_PAGE-1:0][DATA_W-1:0] pg_q;
  logic [DATA_W-1:0]               jmp_q;
  logic [SP_W-1:0]                 sp_q;
  logic [DATA_W-1:0]               st_q;
  logic [NUM_PAGE-1:0]             gate;

  assign gate = {strap.page_z, strap.page_y, strap.page_x, strap.page_d};

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_q  <= '0;
      jmp_q <= '0;
      sp_q  <= '0;
      st_q  <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_PAGE; i++) begin
        if (port == PORT_W'(PORT_PAGE_BASE + i) && gate[i]) pg_q[i] <= wdata;
      end
      if (port == PORT_W'(PORT_JMP))    jmp_q <= wdata;
      if (port == PORT_W'(PORT_SP_LO))  sp_q[DATA_W-1:0] <= wdata;
      if (port == PORT_W'(PORT_SP_HI) && strap.wide_sp) sp_q[SP_W-1:DATA_W] <= wdata;
      if (port == PORT_W'(PORT_STATUS)) st_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= '0;
      for (int i = 0; i < NUM_PAGE; i++) begin
        if (port == PORT_W'(PORT_PAGE_BASE + i)) rdata <= pg_q[i];
      end
      if (port == PORT_W'(PORT_JMP))    rdata <= jmp_q;
      if (port == PORT_W'(PORT_SP_LO))  rdata <= sp_q[DATA_W-1:0];
      if (port == PORT_W'(PORT_SP_HI))  rdata <= sp_q[SP_W-1:DATA_W];
      if (port == PORT_W'(PORT_STATUS)) rdata <= st_q;
    end
  end

  for (genvar g = 0; g < NUM_PAGE; g++) begin : g_page_out
    assign page_o[g] = {pg_q[g], LOW_W'(0)};
  end
  assign jmp_o    = {jmp_q, LOW_W'(0)};
  assign sp_o     = sp_q;
  assign status_o = st_q;

  assert_page_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port == PORT_W'(PORT_PAGE_BASE) && !strap.page_d) |=> $stable(pg_q[0]));

  assert_page_gate_z_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port == PORT_W'(PORT_PAGE_BASE + 3) && !strap.page_z) |=> $stable(pg_q[3]));

  assert_jmp_loads_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port == PORT_W'(PORT_JMP)) |=> (jmp_o[PAGE_W-1:LOW_W] == $past(wdata)));

  assert_splo_keeps_high_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port == PORT_W'(PORT_SP_LO)) |=> $stable(sp_o[SP_W-1:DATA_W]));

  assert_sphi_locked_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port == PORT_W'(PORT_SP_HI) && !strap.wide_sp) |=> $stable(sp_o));

endmodule

// File: rtl/dsr_membus.sv
module dsr_membus #(
  parameter int DATA_W = 8,
  parameter int MEM_AW = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [MEM_AW-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rvalid_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              pend,
  output logic              done,
  output logic [DATA_W-1:0] ret_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      pend      <= 1'b0;
      done      <= 1'b0;
      ret_data  <= '0;
    end else begin
      mem_rd <= req_rd;
      mem_wr <= req_wr;
      if (req_rd || req_wr) mem_addr <= req_addr;
      if (req_wr) mem_wdata <= req_wdata;
      done <= rvalid_i && pend;
      if (rvalid_i && pend) begin
        ret_data <= rdata_i;
        pend     <= 1'b0;
      end else if (req_rd) begin
        pend <= 1'b1;
      end
    end
  end

  assert_bus_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr}));

  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  assert_pend_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (rvalid_i && pend) |=> (!pend && done));

  assert_done_needs_pend_R12: assert property (@(posedge clk) disable iff (rst)
    (!pend) |=> !done);

endmodule

// File: rtl/dspace_router.sv
module dspace_router
  import dsr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int GPR_COUNT = 32,
  parameter int IO_COUNT  = 64,
  parameter int MEM_AW    = 24,
  parameter int PAGE_W    = 24,
  parameter int unsigned DATA_BASE = 'h200000,
  parameter int unsigned IO_BASE   = DATA_BASE + GPR_COUNT,
  localparam int PORT_W   = $clog2(IO_COUNT),
  localparam int GPR_W    = $clog2(GPR_COUNT),
  localparam int SP_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic              strap_page_d,
  input  logic              strap_page_x,
  input  logic              strap_page_y,
  input  logic              strap_page_z,
  input  logic              strap_wide_sp,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [PAGE_W-1:0] page_d,
  output logic [PAGE_W-1:0] page_x,
  output logic [PAGE_W-1:0] page_y,
  output logic [PAGE_W-1:0] page_z,
  output logic [PAGE_W-1:0] page_jmp,
  output logic [SP_W-1:0]   stack_ptr,
  output logic [DATA_W-1:0] status
);

  region_e           rgn;
  logic [PORT_W-1:0] port;
  logic [MEM_AW-1:0] bus_addr;
  strap_t            strap;
  logic [DATA_W-1:0] gpr_q, spec_q, bus_q;
  logic              bus_done;
  logic              loc_valid_q, from_gpr_q;
  logic [PAGE_W-1:0] page_arr [NUM_PAGE];

  assign strap = '{wide_sp: strap_wide_sp, page_z: strap_page_z, page_y: strap_page_y,
                   page_x: strap_page_x, page_d: strap_page_d};

  dsr_decode #(
    .ADDR_W(ADDR_W), .GPR_COUNT(GPR_COUNT), .IO_COUNT(IO_COUNT),
    .MEM_AW(MEM_AW), .DATA_BASE(DATA_BASE), .IO_BASE(IO_BASE)
  ) u_decode (
    .addr(acc_addr), .region(rgn), .port(port), .bus_addr(bus_addr)
  );

  dsr_regfile #(.DATA_W(DATA_W), .DEPTH(GPR_COUNT)) u_gpr (
    .clk(clk),
    .we(acc_wr && rgn == RGN_GPR),
    .re(acc_rd && rgn == RGN_GPR),
    .idx(acc_addr[GPR_W-1:0]),
    .wdata(acc_wdata),
    .rdata(gpr_q)
  );

  dsr_special #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .PORT_W(PORT_W)) u_spec (
    .clk(clk), .rst(rst),
    .wr_en(acc_wr && rgn == RGN_SPEC),
    .rd_en(acc_rd && rgn == RGN_SPEC),
    .port(port), .wdata(acc_wdata), .strap(strap),
    .page_o(page_arr), .jmp_o(page_jmp), .sp_o(stack_ptr),
    .status_o(status), .rdata(spec_q)
  );

  dsr_membus #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_bus (
    .clk(clk), .rst(rst),
    .req_rd(acc_rd && rgn == RGN_BUS),
    .req_wr(acc_wr && rgn == RGN_BUS),
    .req_addr(bus_addr), .req_wdata(acc_wdata),
    .rvalid_i(mem_rvalid), .rdata_i(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pend(busy), .done(bus_done), .ret_data(bus_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_valid_q <= 1'b0;
      from_gpr_q  <= 1'b0;
    end else begin
      loc_valid_q <= acc_rd && rgn != RGN_BUS;
      if (acc_rd) from_gpr_q <= (rgn == RGN_GPR);
    end
  end

  assign rd_valid = loc_valid_q || bus_done;
  assign rd_data  = bus_done ? bus_q : (from_gpr_q ? gpr_q : spec_q);

  assign page_d = page_arr[0];
  assign page_x = page_arr[1];
  assign page_y = page_arr[2];
  assign page_z = page_arr[3];

  // input contract: one strobe at a time, nothing new while a bus read is out
  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    !(acc_rd && acc_wr));

  assert_idle_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(acc_rd || acc_wr));

  assert_gpr_no_bus_R1: assert property (@(posedge clk) disable iff (rst)
    ((acc_rd || acc_wr) && rgn == RGN_GPR) |=> !(mem_rd || mem_wr));

  assert_spec_no_bus_R2: assert property (@(posedge clk) disable iff (rst)
    ((acc_rd || acc_wr) && rgn == RGN_SPEC) |=> !(mem_rd || mem_wr));

  assert_local_read_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && rgn != RGN_BUS) |=> rd_valid);

  assert_no_dual_source_R12: assert property (@(posedge clk) disable iff (rst)
    !(loc_valid_q && bus_done));

endmodule

// File: tb/dspace_router_tb.sv
module dspace_router_tb;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned DATA_BASE = 'h200000;
  localparam int unsigned IO_BASE   = DATA_BASE + 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic        acc_rd = 1'b0, acc_wr = 1'b0;
  logic        s_d = 1'b0, s_x = 1'b0, s_y = 1'b0, s_z = 1'b0, s_w = 1'b0;
  logic        rd_valid, busy, mem_rd, mem_wr;
  logic [7:0]  rd_data, mem_wdata;
  logic [23:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [23:0] page_d, page_x, page_y, page_z, page_jmp;
  logic [15:0] stack_ptr;
  logic [7:0]  status;

  always #(CLK_PERIOD/2) clk = ~clk;

  dspace_router #(.DATA_BASE(DATA_BASE)) u_dut (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rd(acc_rd), .acc_wr(acc_wr),
    .strap_page_d(s_d), .strap_page_x(s_x), .strap_page_y(s_y),
    .strap_page_z(s_z), .strap_wide_sp(s_w),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .page_d(page_d), .page_x(page_x), .page_y(page_y), .page_z(page_z),
    .page_jmp(page_jmp), .stack_ptr(stack_ptr), .status(status)
  );

  int checks = 0, failures = 0;
  bit done_flag = 0;

  // behavioural reference state
  int    m_gpr [32];
  int    m_pg [4];
  int    m_jmp = 0, m_sp = 0, m_st = 0;
  bit    m_pend = 0;
  bit    e_rdv = 0, e_mr = 0, e_mw = 0, e_busy = 0;
  int    e_rdd = 0, e_ma = 0, e_mwd = 0;
  string e_tag = "R11";

  task automatic chk(input bit ok, input string what, input string act, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%s exp=%s", e_tag, what, act, exp);
    end
  endtask

  task automatic compare();
    bit ok;
    ok = (rd_valid == e_rdv) && (!e_rdv || rd_data == 8'(e_rdd));
    chk(ok, "read", $sformatf("%0b/%02h", rd_valid, rd_data), $sformatf("%0b/%02h", e_rdv, e_rdd));
    ok = (mem_rd == e_mr) && (mem_wr == e_mw) &&
         (!(e_mr || e_mw) || mem_addr == 24'(e_ma)) && (!e_mw || mem_wdata == 8'(e_mwd));
    chk(ok, "bus", $sformatf("%0b%0b/%06h/%02h", mem_rd, mem_wr, mem_addr, mem_wdata),
        $sformatf("%0b%0b/%06h/%02h", e_mr, e_mw, e_ma, e_mwd));
    chk(busy == e_busy, "busy", $sformatf("%0b", busy), $sformatf("%0b", e_busy));
    ok = page_d == 24'(m_pg[0] << 16) && page_x == 24'(m_pg[1] << 16) &&
         page_y == 24'(m_pg[2] << 16) && page_z == 24'(m_pg[3] << 16) &&
         page_jmp == 24'(m_jmp << 16) && stack_ptr == 16'(m_sp) && status == 8'(m_st);
    chk(ok, "state",
        $sformatf("%06h %06h %06h %06h %06h %04h %02h", page_d, page_x, page_y, page_z, page_jmp, stack_ptr, status),
        $sformatf("%02h %02h %02h %02h %02h %04h %02h", m_pg[0], m_pg[1], m_pg[2], m_pg[3], m_jmp, m_sp, m_st));
  endtask

  task automatic spec_access(input bit wr, input int p, input int wd);
    bit g[4];
    g = '{s_d, s_x, s_y, s_z};
    if (p >= 'h38 && p <= 'h3B) begin
      if (wr) begin if (g[p - 'h38]) m_pg[p - 'h38] = wd; end
      else e_rdd = m_pg[p - 'h38];
    end else if (p == 'h3C) begin
      if (wr) m_jmp = wd; else e_rdd = m_jmp;
    end else if (p == 'h3D) begin
      if (wr) m_sp = (m_sp & 'hFF00) | wd; else e_rdd = m_sp & 'hFF;
    end else if (p == 'h3E) begin
      if (wr) begin if (s_w) m_sp = (m_sp & 'hFF) | (wd << 8); end
      else e_rdd = m_sp >> 8;
    end else begin
      if (wr) m_st = wd; else e_rdd = m_st;
    end
    if (!wr) e_rdv = 1;
  endtask

  task automatic cyc(input bit rd, input bit wr, input int a, input int wd,
                     input bit rv, input int rdat, input string tag);
    @(negedge clk);
    compare();
    acc_rd = rd; acc_wr = wr; acc_addr = 16'(a); acc_wdata = 8'(wd);
    mem_rvalid = rv; mem_rdata = 8'(rdat);
    e_rdv = 0; e_mr = 0; e_mw = 0;
    if (rv && m_pend) begin e_rdv = 1; e_rdd = rdat; m_pend = 0; end
    if (rd || wr) begin
      if (a < 32) begin
        if (wr) m_gpr[a] = wd; else begin e_rdv = 1; e_rdd = m_gpr[a]; end
      end else if (a < 96 && (a - 32) >= 'h38) begin
        spec_access(wr, a - 32, wd);
      end else begin
        e_ma = (a < 96) ? int'(IO_BASE) + (a - 32) : int'(DATA_BASE) + a;
        if (wr) begin e_mw = 1; e_mwd = wd; end
        else begin e_mr = 1; m_pend = 1; end
      end
    end
    e_busy = m_pend;
    e_tag = tag;
  endtask

  task automatic wr_t(input int a, input int d, input string tag); cyc(0, 1, a, d, 0, 0, tag); endtask
  task automatic rd_t(input int a, input string tag);              cyc(1, 0, a, 0, 0, 0, tag); endtask
  task automatic idle(input string tag);                           cyc(0, 0, 0, 0, 0, 0, tag); endtask
  task automatic bus_rd(input int a, input int lat, input int d, input string tag);
    rd_t(a, tag);
    for (int i = 0; i < lat; i++) idle(tag);
    cyc(0, 0, 0, 0, 1, d, tag);
    idle(tag);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done_flag) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    foreach (m_pg[i]) m_pg[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    idle("R11");
    // R1: register file, boundaries 0 and 31
    wr_t(0, 'h5A, "R1"); wr_t(31, 'hC3, "R1"); wr_t(7, 'h11, "R1");
    rd_t(31, "R1"); rd_t(0, "R1"); rd_t(7, "R1"); idle("R1");
    // R8: first I/O address 32 and last fall-through port 0x37
    wr_t(32, 'hA5, "R8"); idle("R8");
    bus_rd(32, 2, 'h3C, "R8");
    wr_t(32 + 'h37, 'h99, "R8");
    bus_rd(32 + 'h37, 0, 'h77, "R8");
    // R9: first memory address 96 and the top of the space
    wr_t(96, 'h42, "R9"); idle("R9");
    bus_rd(96, 3, 'hE1, "R9");
    bus_rd('hFFFF, 1, 'h0F, "R9");
    // R10: stray valid with nothing outstanding
    cyc(0, 0, 0, 0, 1, 'hAA, "R10"); idle("R10");
    // R7: status port at address 95
    wr_t(95, 'h81, "R7"); rd_t(95, "R7"); idle("R7");
    // R3: page registers with straps off then on
    for (int i = 0; i < 4; i++) wr_t(32 + 'h38 + i, 'h10 + i, "R3");
    for (int i = 0; i < 4; i++) rd_t(32 + 'h38 + i, "R3");
    idle("R3");
    s_d = 1; s_x = 1; s_y = 1; s_z = 1;
    for (int i = 0; i < 4; i++) wr_t(32 + 'h38 + i, 'hF0 + i, "R3");
    for (int i = 0; i < 4; i++) rd_t(32 + 'h38 + i, "R3");
    idle("R3");
    s_x = 0; s_z = 0;
    wr_t(32 + 'h39, 'h01, "R3"); wr_t(32 + 'h3A, 'h02, "R3"); wr_t(32 + 'h3B, 'h03, "R3");
    idle("R3");
    // R4: jump page always written
    s_d = 0; s_y = 0;
    wr_t(32 + 'h3C, 'hB7, "R4"); rd_t(32 + 'h3C, "R4"); idle("R4");
    // R5 / R6: stack pointer halves
    wr_t(32 + 'h3D, 'h34, "R5"); wr_t(32 + 'h3E, 'h12, "R6");
    rd_t(32 + 'h3D, "R5"); rd_t(32 + 'h3E, "R6"); idle("R6");
    s_w = 1;
    wr_t(32 + 'h3E, 'h12, "R6"); wr_t(32 + 'h3D, 'h78, "R5");
    rd_t(32 + 'h3E, "R6"); rd_t(32 + 'h3D, "R5"); idle("R5");
    s_w = 0;
    wr_t(32 + 'h3E, 'hEE, "R6"); rd_t(32 + 'h3E, "R6");
    // R2: a local write then a bus access back to back
    wr_t(32 + 'h3F, 'h07, "R2"); wr_t(33, 'h66, "R12"); idle("R12");
    idle("R12");
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule